// File: doc/BRIEF.md
# DMA Controller Register Bank with Interrupt Outputs

This block is the software-visible face of a multi-channel DMA controller. It decodes word-addressed reads and writes on a 4 KB register window. It holds a global configuration word, a sync word, and five 32-bit words per channel: source address, destination address, link pointer, control and configuration. It also keeps the raw terminal-count and error flags of every channel, masks them with per-channel configuration bits, and drives three interrupt lines. The channel count is a parameter (8 or 2).

A separate transfer engine reports progress through a side port. It can reload all five words of one channel in a cycle and raise terminal-count or error flags. After software changes a channel configuration or the global configuration, the bank raises a one-cycle start pulse so that the engine rescans its channels. Reads are combinational: the read data is valid in the same cycle as the access. Any address the bank does not decode returns zero.

Top module: `dma_regbank`

## Requirements
- R1: After reset every channel word, the global configuration, the sync word and all raw flags read as zero, and irqErr, irqTc, irqAny and startPulse are low.
- R2: Channel words sit at word address 64 + 8*ch + sel, with ch = wordAddr[5:3] and sel = wordAddr[2:0]. The sel values are 0 source, 1 destination, 2 link pointer, 3 control and 4 configuration. Each word reads back the full 32 bits written.
- R3: Reads of channel sel 5 to 7, of a channel index at or above NUM_CH, of global word indices 8 to 11 and 14 to 63, and of any other unmapped address return zero. Writes to those addresses change no register.
- R4: Global word index 7 reads a bitmap with bit ch set when configuration bit 0 (enable) of channel ch is 1.
- R5: A write to global index 2 clears the raw terminal-count flags at the bit positions where the data is 1. A write to index 4 does the same for the raw error flags. When a set input and a clear hit the same flag in the same cycle, the flag stays set.
- R6: Index 5 reads the raw terminal-count flags and index 6 reads the raw error flags. Index 1 reads the raw terminal-count flags ANDed with configuration bit 15 of each channel. Index 3 reads the raw error flags ANDed with configuration bit 14 of each channel. Index 0 reads the OR of indices 1 and 3.
- R7: irqTc is high when any masked terminal-count flag is set, irqErr is high when any masked error flag is set, and irqAny is high when either of them is high.
- R8: Word addresses 0x3F8 to 0x3FF return identification bytes 0x80 (0x81 when NUM_CH is 2), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1, in that address order, zero-extended.
- R9: startPulse is high for exactly the one cycle after a write to a channel configuration word or to global index 12.
- R10: When updValid is high, all five words of channel updCh are loaded from the update port. A bus write to one of those words in the same cycle takes priority for that word.
- R11: Global index 12 (configuration) and index 13 (sync) each hold and read back a full 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| wordAddr | input | 10 | Word address in the 4 KB window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle; zero when not reading |
| updValid | input | 1 | Engine reloads a channel |
| updCh | input | 3 | Channel that the engine reloads |
| updSrc | input | 32 | New source address |
| updDst | input | 32 | New destination address |
| updLli | input | 32 | New link pointer |
| updCtrl | input | 32 | New control word |
| updCfg | input | 32 | New configuration word |
| tcSet | input | NUM_CH | Per-channel terminal-count flag set |
| errSet | input | NUM_CH | Per-channel error flag set |
| irqErr | output | 1 | Masked error interrupt |
| irqTc | output | 1 | Masked terminal-count interrupt |
| irqAny | output | 1 | Combined interrupt |
| startPulse | output | 1 | One-cycle rescan request to the engine |

## Verification
The interrupt path is driven with flags on channels whose configurations differ only in the two mask bits. This separates the raw views from the masked views, and a fault in one mask from a fault in the other. Mask bits are then changed while a flag is already set, so the status follows the configuration and not the moment the flag was set. The decode is probed on mapped and unmapped neighbours: sel 5, software-request indices and holes. After each write to such an address, the real registers are read back unchanged. Two same-cycle collisions are driven: set against clear, and an engine reload against a bus write. Each has an outcome that only one priority order produces.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;
  localparam int IDX_W  = 3;

  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_ERRM_BIT  = 14;
  localparam int CFG_TCM_BIT   = 15;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_LLI  = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_CFG  = 3'd4;

  typedef enum logic [3:0] {
    RD_NONE, RD_CH, RD_ANY, RD_TCM, RD_ERRM, RD_RAWTC, RD_RAWERR,
    RD_ENMAP, RD_GCFG, RD_SYNC, RD_ID
  } rdKind_e;

  typedef struct packed {
    logic             chWr;
    logic [IDX_W-1:0] ch;
    logic [2:0]       sel;
    logic             gCfgWr;
    logic             syncWr;
    logic             tcClr;
    logic             errClr;
    rdKind_e          rd;
    logic [2:0]       idIdx;
  } strobe_t;

  function automatic logic [7:0] idByte(input logic [2:0] k, input int nCh);
    case (k)
      3'd0: idByte = (nCh == 8) ? 8'h80 : 8'h81;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h0A;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dma_regbank_ctrl.sv
module dma_regbank_ctrl
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] wordAddr,
  output strobe_t           stb,
  output logic              startPulse
);
  localparam logic [3:0] REGION_GLB = 4'h0;
  localparam logic [3:0] REGION_CH  = 4'h1;
  localparam logic [6:0] REGION_ID  = 7'h7F;

  logic isWr, isRd, inCh, inGlb, inId, chOk;
  logic [5:0] gIdx;

  assign isWr  = busSel && busWrite;
  assign isRd  = busSel && !busWrite;
  assign inCh  = wordAddr[9:6] == REGION_CH;
  assign inGlb = wordAddr[9:6] == REGION_GLB;
  assign inId  = wordAddr[9:3] == REGION_ID;
  assign gIdx  = wordAddr[5:0];
  assign chOk  = inCh && (int'(wordAddr[5:3]) < NUM_CH) && (wordAddr[2:0] <= SEL_CFG);

  always_comb begin
    stb        = '0;
    stb.ch     = wordAddr[5:3];
    stb.sel    = wordAddr[2:0];
    stb.idIdx  = wordAddr[2:0];
    stb.chWr   = isWr && chOk;
    stb.gCfgWr = isWr && inGlb && gIdx == 6'd12;
    stb.syncWr = isWr && inGlb && gIdx == 6'd13;
    stb.tcClr  = isWr && inGlb && gIdx == 6'd2;
    stb.errClr = isWr && inGlb && gIdx == 6'd4;
    stb.rd     = RD_NONE;
    if (isRd) begin
      if (chOk)      stb.rd = RD_CH;
      else if (inId) stb.rd = RD_ID;
      else if (inGlb) begin
        case (gIdx)
          6'd0:    stb.rd = RD_ANY;
          6'd1:    stb.rd = RD_TCM;
          6'd3:    stb.rd = RD_ERRM;
          6'd5:    stb.rd = RD_RAWTC;
          6'd6:    stb.rd = RD_RAWERR;
          6'd7:    stb.rd = RD_ENMAP;
          6'd12:   stb.rd = RD_GCFG;
          6'd13:   stb.rd = RD_SYNC;
          default: stb.rd = RD_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) startPulse <= 1'b0;
    else       startPulse <= (stb.chWr && stb.sel == SEL_CFG) || stb.gCfgWr;
  end
endmodule

// File: rtl/dma_regbank_dp.sv
module dma_regbank_dp
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              updValid,
  input  logic [IDX_W-1:0]  updCh,
  input  logic [DATA_W-1:0] updSrc,
  input  logic [DATA_W-1:0] updDst,
  input  logic [DATA_W-1:0] updLli,
  input  logic [DATA_W-1:0] updCtrl,
  input  logic [DATA_W-1:0] updCfg,
  input  logic [NUM_CH-1:0] tcSet,
  input  logic [NUM_CH-1:0] errSet,
  output logic              irqErr,
  output logic              irqTc,
  output logic              irqAny
);
  logic [DATA_W-1:0] srcR [NUM_CH];
  logic [DATA_W-1:0] dstR [NUM_CH];
  logic [DATA_W-1:0] lliR [NUM_CH];
  logic [DATA_W-1:0] ctlR [NUM_CH];
  logic [DATA_W-1:0] cfgR [NUM_CH];
  logic [DATA_W-1:0] gCfgR, syncR;
  logic [NUM_CH-1:0] rawTc, rawErr, tcMask, errMask, enMap, tcMsk, errMsk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        srcR[c] <= '0; dstR[c] <= '0; lliR[c] <= '0; ctlR[c] <= '0; cfgR[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (updValid && updCh == IDX_W'(c)) begin
          srcR[c] <= updSrc; dstR[c] <= updDst; lliR[c] <= updLli;
          ctlR[c] <= updCtrl; cfgR[c] <= updCfg;
        end
        if (stb.chWr && stb.ch == IDX_W'(c)) begin
          case (stb.sel)
            SEL_SRC:  srcR[c] <= busWdata;
            SEL_DST:  dstR[c] <= busWdata;
            SEL_LLI:  lliR[c] <= busWdata;
            SEL_CTRL: ctlR[c] <= busWdata;
            default:  cfgR[c] <= busWdata;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gCfgR <= '0; syncR <= '0; rawTc <= '0; rawErr <= '0;
    end else begin
      if (stb.gCfgWr) gCfgR <= busWdata;
      if (stb.syncWr) syncR <= busWdata;
      rawTc  <= (rawTc  & ~(stb.tcClr  ? busWdata[NUM_CH-1:0] : '0)) | tcSet;
      rawErr <= (rawErr & ~(stb.errClr ? busWdata[NUM_CH-1:0] : '0)) | errSet;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chBits
    assign tcMask[g]  = cfgR[g][CFG_TCM_BIT];
    assign errMask[g] = cfgR[g][CFG_ERRM_BIT];
    assign enMap[g]   = cfgR[g][CFG_EN_BIT];
  end

  assign tcMsk  = rawTc & tcMask;
  assign errMsk = rawErr & errMask;
  assign irqTc  = |tcMsk;
  assign irqErr = |errMsk;
  assign irqAny = irqTc || irqErr;

  always_comb begin
    busRdata = '0;
    case (stb.rd)
      RD_CH: begin
        case (stb.sel)
          SEL_SRC:  busRdata = srcR[stb.ch];
          SEL_DST:  busRdata = dstR[stb.ch];
          SEL_LLI:  busRdata = lliR[stb.ch];
          SEL_CTRL: busRdata = ctlR[stb.ch];
          default:  busRdata = cfgR[stb.ch];
        endcase
      end
      RD_ANY:    busRdata = DATA_W'(tcMsk | errMsk);
      RD_TCM:    busRdata = DATA_W'(tcMsk);
      RD_ERRM:   busRdata = DATA_W'(errMsk);
      RD_RAWTC:  busRdata = DATA_W'(rawTc);
      RD_RAWERR: busRdata = DATA_W'(rawErr);
      RD_ENMAP:  busRdata = DATA_W'(enMap);
      RD_GCFG:   busRdata = gCfgR;
      RD_SYNC:   busRdata = syncR;
      RD_ID:     busRdata = DATA_W'(idByte(stb.idIdx, NUM_CH));
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              updValid,
  input  logic [IDX_W-1:0]  updCh,
  input  logic [DATA_W-1:0] updSrc,
  input  logic [DATA_W-1:0] updDst,
  input  logic [DATA_W-1:0] updLli,
  input  logic [DATA_W-1:0] updCtrl,
  input  logic [DATA_W-1:0] updCfg,
  input  logic [NUM_CH-1:0] tcSet,
  input  logic [NUM_CH-1:0] errSet,
  output logic              irqErr,
  output logic              irqTc,
  output logic              irqAny,
  output logic              startPulse
);
  strobe_t stb;

  dma_regbank_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .wordAddr(wordAddr), .stb(stb), .startPulse(startPulse)
  );

  dma_regbank_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .busRdata(busRdata),
    .updValid(updValid), .updCh(updCh), .updSrc(updSrc), .updDst(updDst),
    .updLli(updLli), .updCtrl(updCtrl), .updCfg(updCfg),
    .tcSet(tcSet), .errSet(errSet),
    .irqErr(irqErr), .irqTc(irqTc), .irqAny(irqAny)
  );
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] wordAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [NUM_CH-1:0] tcSet,
  input logic              irqTc,
  input logic              startPulse
);
  // R9
  gcfg_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && wordAddr == 10'd12) |=> startPulse);

  // R9
  start_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(busSel && busWrite));

  // R5
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && wordAddr == 10'd2 && busWdata[NUM_CH-1:0] == '1 && tcSet == '0)
    |=> !irqTc);

  // R3
  hole_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && wordAddr >= 10'd14 && wordAddr <= 10'd63) |-> busRdata == '0);

  // R8
  id_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && wordAddr == 10'h3F9) |-> busRdata == 32'h10);
endmodule

bind dma_regbank dma_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/dma_regbank_bench.sv
module dma_regbank_bench;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [9:0] wordAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic updValid = 1'b0;
  logic [2:0] updCh = '0;
  logic [31:0] updSrc = '0, updDst = '0, updLli = '0, updCtrl = '0, updCfg = '0;
  logic [NCH-1:0] tcSet = '0, errSet = '0;
  logic irqErr, irqTc, irqAny, startPulse;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  dma_regbank #(.NUM_CH(NCH)) u_dma_regbank (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each read response against the scoreboard queue
  always @(negedge clk) begin
    if (busSel && !busWrite) begin
      if (expQ.size() == 0) check(busRdata, 32'hx, "scoreboard empty");
      else check(busRdata, expQ.pop_front(), tagQ.pop_front());
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    busSel = 1; busWrite = 1; wordAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    busSel = 1; busWrite = 0; wordAddr = a;
    @(posedge clk); #1;
    busSel = 0;
  endtask

  function automatic logic [9:0] chA(input int ch, input int sel);
    return 10'(64 + 8 * ch + sel);
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [7:0] ids [8];
    ids = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(posedge clk); #1;
    rstN = 1;
    // R1 reset state
    check({irqErr, irqTc, irqAny, startPulse}, 4'b0, "R1 outputs after reset");
    rd(chA(3, 0), 0, "R1 channel word after reset");
    rd(10'd12, 0, "R1 global config after reset");
    rd(10'd5, 0, "R1 raw tc after reset");

    // R2 channel register round trip
    wr(chA(3, 0), 32'hA5A50001); wr(chA(3, 1), 32'h5A5A0002);
    wr(chA(3, 2), 32'h12345678); wr(chA(3, 3), 32'h8000_0FFF);
    rd(chA(3, 0), 32'hA5A50001, "R2 src");
    rd(chA(3, 1), 32'h5A5A0002, "R2 dst");
    rd(chA(3, 2), 32'h12345678, "R2 lli");
    rd(chA(3, 3), 32'h8000_0FFF, "R2 ctrl");

    // R9 start pulse after channel config write
    wr(chA(7, 4), 32'h0000_C001);
    @(negedge clk); check(startPulse, 1, "R9 pulse after channel cfg write");
    @(negedge clk); check(startPulse, 0, "R9 pulse lasts one cycle");
    @(posedge clk); #1;
    wr(chA(3, 3), 32'h1);
    @(negedge clk); check(startPulse, 0, "R9 no pulse after ctrl write");
    @(posedge clk); #1;
    rd(chA(7, 4), 32'h0000_C001, "R2 cfg");

    // R4 enable bitmap
    wr(chA(3, 4), 32'h1);
    rd(10'd7, 32'h88, "R4 enable bitmap");

    // R11 global config and sync
    wr(10'd12, 32'hCAFE0001);
    @(negedge clk); check(startPulse, 1, "R9 pulse after global cfg write");
    @(posedge clk); #1;
    wr(10'd13, 32'hDEADBEEF);
    rd(10'd12, 32'hCAFE0001, "R11 global cfg");
    rd(10'd13, 32'hDEADBEEF, "R11 sync");

    // R3 holes and ignored writes
    wr(chA(0, 5), 32'hFFFF_FFFF); wr(10'd9, 32'hFFFF_FFFF); wr(10'd14, 32'hFFFF_FFFF);
    rd(chA(0, 5), 0, "R3 sel5 reads zero");
    rd(10'd9, 0, "R3 soft request reads zero");
    rd(10'd20, 0, "R3 hole reads zero");
    rd(10'd300, 0, "R3 unmapped region reads zero");
    rd(chA(0, 0), 0, "R3 ch0 src untouched");
    rd(chA(0, 4), 0, "R3 ch0 cfg untouched");
    rd(10'd13, 32'hDEADBEEF, "R3 sync untouched");

    // R8 identification bytes
    for (int k = 0; k < 8; k++) rd(10'(10'h3F8 + k), 32'(ids[k]), "R8 id byte");

    // R10 engine update, bus write wins on collision
    updValid = 1; updCh = 3'd5;
    updSrc = 32'h1111; updDst = 32'h2222; updLli = 32'h3333; updCtrl = 32'h4444; updCfg = 32'h5550;
    wr(chA(5, 0), 32'h9999);
    updValid = 0;
    rd(chA(5, 0), 32'h9999, "R10 bus write wins");
    rd(chA(5, 1), 32'h2222, "R10 dst loaded");
    rd(chA(5, 2), 32'h3333, "R10 lli loaded");
    rd(chA(5, 3), 32'h4444, "R10 ctrl loaded");
    rd(chA(5, 4), 32'h5550, "R10 cfg loaded");

    // R5 R6 R7 interrupts: ch7 has both masks, ch3 none
    tcSet = 8'h88; @(posedge clk); #1; tcSet = 0;
    check({irqTc, irqErr, irqAny}, 3'b101, "R7 tc irq from ch7");
    rd(10'd5, 32'h88, "R6 raw tc");
    rd(10'd1, 32'h80, "R6 masked tc");
    errSet = 8'h08; @(posedge clk); #1; errSet = 0;
    check(irqErr, 0, "R7 unmasked err gives no irq");
    rd(10'd6, 32'h08, "R6 raw err");
    rd(10'd3, 32'h00, "R6 masked err");
    errSet = 8'h80; @(posedge clk); #1; errSet = 0;
    check(irqErr, 1, "R7 masked err irq");
    rd(10'd0, 32'h80, "R6 combined status");
    wr(10'd2, 32'h80);
    check({irqTc, irqAny}, 2'b01, "R5 tc clear leaves err");
    rd(10'd5, 32'h08, "R5 raw tc after clear");
    wr(chA(3, 4), 32'h8001);
    rd(10'd1, 32'h08, "R6 mask follows cfg bit15");
    check(irqTc, 1, "R7 tc irq after mask set");
    wr(10'd4, 32'hFF);
    check(irqErr, 0, "R5 err clear");
    rd(10'd6, 0, "R5 raw err cleared");
    tcSet = 8'h01; wr(10'd2, 32'h01); tcSet = 0;
    rd(10'd5, 32'h09, "R5 set wins over clear");
    wr(10'd2, 32'hFF);
    check({irqTc, irqAny}, 2'b00, "R7 all clear");

    @(negedge clk);
    check(32'(expQ.size()), 0, "scoreboard drained");
    finish();
  end
endmodule